// File: doc/BRIEF.md
# ROM Code Patch Unit

The unit sits between a processor and its program ROM and swaps individual ROM bytes for corrected values without touching the ROM. It holds a bank of ten patch cells. Each cell keeps a 24-bit compare address and an 8-bit replacement byte. In patch mode, every cell whose select bit is set compares its address with the live bus address. On a match, the unit places the cell's byte on its data output, raises a patch output enable and drops the ROM enable. This happens in the same read cycle, with no added wait state.

Software configures the bank through six write-only byte registers. Three of them hold the address bytes, one holds the replacement byte, and two hold the select and mode bits. The address and data registers form a shared window. In write mode, a write to one of them lands in the single selected cell. The select mask then becomes the per-cell compare enable once the global mode bit is set. Software writes the second enable register first and the first enable register last, setting the mode bit in that final write.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset the unit is in write mode and no cell is selected, so the data output equals `rom_data_i`, `patch_oe_o` is 0 and `rom_en_o` follows `bus_rd_i`. Every cell holds address 0xFFFFFF and data 0x00.
- R2: Register offsets from the base 0x1E64 are fixed. Offset 0 holds address bits 7:0, offset 1 holds bits 15:8 and offset 2 holds bits 23:16. Offset 3 holds the replacement byte. In write mode with exactly one select bit set, writing any of these offsets stores the byte into the selected cell on the clock edge of the write.
- R3: A write to offsets 0 to 3 in write mode is ignored when zero select bits or more than one select bit are set. No cell changes.
- R4: Offset 4 is enable register 0. Bit 0 is the mode bit (1 = patch mode) and bits 7:1 select cells 0 to 6. Offset 5 is enable register 1. Bits 2:0 select cells 7 to 9, and bits 7:3 have no effect.
- R5: In patch mode, a cell that is selected and whose address equals `bus_addr_i` replaces the output byte with its data byte. When `bus_rd_i` is 1, `patch_oe_o` is 1 and `rom_en_o` is 0.
- R6: When no selected cell matches, or the unit is in write mode, `data_o` equals `rom_data_i` and `patch_oe_o` is 0. Unselected cells never match.
- R7: When several selected cells match the same address, the lowest-indexed one supplies the byte.
- R8: Mode changes take effect from the clock edge that writes enable register 0. Patching starts immediately after the edge that sets the mode bit, and stops immediately after the edge that clears it.
- R9: Writes to offsets 0 to 3 while in patch mode are ignored.
- R10: Writes with `cfg_we_i` low, and writes to addresses outside 0x1E64 to 0x1E69, change no state.
- R11: Substitution is combinational from `bus_addr_i` and `rom_data_i`. The outputs change within the same cycle as the address, and `patch_oe_o` and `rom_en_o` are gated by `bus_rd_i` while `data_o` is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 16 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write byte |
| bus_addr_i | input | 24 | Current processor bus address |
| bus_rd_i | input | 1 | Read cycle in progress |
| rom_data_i | input | 8 | Byte from the program ROM |
| data_o | output | 8 | Byte returned to the processor |
| patch_oe_o | output | 1 | Patch byte drives the data bus |
| rom_en_o | output | 1 | ROM may drive the data bus |

## Verification
A corrupted select mask or mode bit shows up in the same cycle as a wrong substitution at the ports. A corrupted cell address or byte stays hidden until that cell is enabled and its address is presented. The bench therefore probes stored addresses, and their neighbours, right after each change of configuration. A store that goes to the wrong cell, or that is accepted under a multi-bit or empty mask, shows up only when that cell is later enabled alone. Directed cases cover this, alongside random sequences that are compared with a bench reference model on every probe.

// File: rtl/rpu_pkg.sv
package rpu_pkg;
  localparam int BYTE_W    = 8;
  localparam int EN0_SELS  = 7;  // select bits held in enable register 0
  localparam int EXTRA_REG = 3;  // data, enable 0, enable 1
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rpu_reg_decode.sv
module rpu_reg_decode
  import rpu_pkg::*;
#(
  parameter int          N_CELLS    = 10,
  parameter int          ADDR_BYTES = 3,
  parameter int          CFG_AW     = 16,
  parameter int unsigned CFG_BASE   = 32'h1E64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CFG_AW-1:0]     cfg_addr_i,
  input  byte_t                 cfg_wdata_i,
  output logic                  mode_o,
  output logic [N_CELLS-1:0]    sel_o,
  output logic [ADDR_BYTES-1:0] addr_byte_we_o,
  output logic                  data_we_o
);
  localparam int DATA_OFF = ADDR_BYTES;
  localparam int EN0_OFF  = ADDR_BYTES + 1;
  localparam int EN1_OFF  = ADDR_BYTES + 2;

  logic [CFG_AW-1:0]  off;
  logic               wr_en0, wr_en1, store_ok;
  logic               mode_q;
  logic [N_CELLS-1:0] sel_q, sel_d;

  assign off    = cfg_addr_i - CFG_AW'(CFG_BASE);
  assign wr_en0 = cfg_we_i && (off == CFG_AW'(EN0_OFF));
  assign wr_en1 = cfg_we_i && (off == CFG_AW'(EN1_OFF));

  // stores need write mode and a single selected cell
  assign store_ok = !mode_q && (sel_q != '0) &&
                    ((sel_q & (sel_q - N_CELLS'(1))) == '0);

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_abyte
    assign addr_byte_we_o[k] = cfg_we_i && store_ok && (off == CFG_AW'(k));
  end
  assign data_we_o = cfg_we_i && store_ok && (off == CFG_AW'(DATA_OFF));

  for (genvar i = 0; i < N_CELLS; i++) begin : g_sel
    if (i < EN0_SELS) begin : g_r0
      assign sel_d[i] = wr_en0 ? cfg_wdata_i[i+1] : sel_q[i];
    end else begin : g_r1
      assign sel_d[i] = wr_en1 ? cfg_wdata_i[i-EN0_SELS] : sel_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (wr_en0) mode_q <= cfg_wdata_i[0];
      sel_q <= sel_d;
    end
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/rpu_cell.sv
module rpu_cell
  import rpu_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int AW         = ADDR_BYTES * BYTE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_BYTES-1:0] addr_byte_we_i,
  input  logic                  data_we_i,
  input  byte_t                 wbyte_i,
  input  logic                  cmp_en_i,
  input  logic [AW-1:0]         bus_addr_i,
  output logic                  hit_o,
  output logic [AW-1:0]         addr_o,
  output byte_t                 data_o
);
  logic [AW-1:0] addr_q;
  byte_t         data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '1;
      data_q <= '0;
    end else begin
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (addr_byte_we_i[k]) addr_q[k*BYTE_W +: BYTE_W] <= wbyte_i;
      end
      if (data_we_i) data_q <= wbyte_i;
    end
  end

  assign hit_o  = cmp_en_i && (addr_q == bus_addr_i);
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/rpu_prio_mux.sv
module rpu_prio_mux
  import rpu_pkg::*;
#(
  parameter int N_CELLS = 10
) (
  input  logic [N_CELLS-1:0]        hit_i,
  input  logic [N_CELLS*BYTE_W-1:0] data_flat_i,
  output logic [N_CELLS-1:0]        grant_o,
  output logic                      any_o,
  output byte_t                     data_o
);
  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    data_o  = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (hit_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        any_o      = 1'b1;
        data_o     = data_flat_i[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
  import rpu_pkg::*;
#(
  parameter int          N_CELLS    = 10,
  parameter int          ADDR_BYTES = 3,
  parameter int          CFG_AW     = 16,
  parameter int unsigned CFG_BASE   = 32'h1E64,
  parameter int          AW         = ADDR_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        rom_data_i,
  output logic [7:0]        data_o,
  output logic              patch_oe_o,
  output logic              rom_en_o
);
  logic                      mode_q;
  logic [N_CELLS-1:0]        sel_q, hit, grant;
  logic [ADDR_BYTES-1:0]     addr_byte_we;
  logic                      data_we, any_hit;
  logic [N_CELLS*AW-1:0]     cell_addr_flat;
  logic [N_CELLS*BYTE_W-1:0] cell_data_flat;
  byte_t                     patch_byte;

  rpu_reg_decode #(
    .N_CELLS(N_CELLS), .ADDR_BYTES(ADDR_BYTES),
    .CFG_AW(CFG_AW), .CFG_BASE(CFG_BASE)
  ) u_dec (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .mode_o(mode_q), .sel_o(sel_q),
    .addr_byte_we_o(addr_byte_we), .data_we_o(data_we)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    rpu_cell #(.ADDR_BYTES(ADDR_BYTES), .AW(AW)) u_cell (
      .clk_i, .rst_ni,
      .addr_byte_we_i(addr_byte_we & {ADDR_BYTES{sel_q[i]}}),
      .data_we_i(data_we & sel_q[i]),
      .wbyte_i(cfg_wdata_i),
      .cmp_en_i(mode_q & sel_q[i]),
      .bus_addr_i,
      .hit_o(hit[i]),
      .addr_o(cell_addr_flat[i*AW +: AW]),
      .data_o(cell_data_flat[i*BYTE_W +: BYTE_W])
    );
  end

  rpu_prio_mux #(.N_CELLS(N_CELLS)) u_mux (
    .hit_i(hit), .data_flat_i(cell_data_flat),
    .grant_o(grant), .any_o(any_hit), .data_o(patch_byte)
  );

  assign data_o     = any_hit ? patch_byte : rom_data_i;
  assign patch_oe_o = bus_rd_i & any_hit;
  assign rom_en_o   = bus_rd_i & ~any_hit;
endmodule

// File: rtl/rpu_checker.sv
module rpu_checker #(
  parameter int          N_CELLS    = 10,
  parameter int          ADDR_BYTES = 3,
  parameter int          CFG_AW     = 16,
  parameter int unsigned CFG_BASE   = 32'h1E64,
  parameter int          AW         = ADDR_BYTES * 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_we_i,
  input logic [CFG_AW-1:0]     cfg_addr_i,
  input logic [7:0]            cfg_wdata_i,
  input logic                  bus_rd_i,
  input logic [7:0]            rom_data_i,
  input logic [7:0]            data_o,
  input logic                  patch_oe_o,
  input logic                  rom_en_o,
  input logic                  mode_i,
  input logic [N_CELLS-1:0]    sel_i,
  input logic [N_CELLS-1:0]    hit_i,
  input logic [N_CELLS-1:0]    grant_i,
  input logic [N_CELLS*AW-1:0] cell_addr_i,
  input logic [N_CELLS*8-1:0]  cell_data_i
);
  logic [CFG_AW-1:0] off;
  logic              store_wr, en0_clr;
  assign off      = cfg_addr_i - CFG_AW'(CFG_BASE);
  assign store_wr = cfg_we_i && (off <= CFG_AW'(ADDR_BYTES));
  assign en0_clr  = cfg_we_i && (off == CFG_AW'(ADDR_BYTES + 1)) && !cfg_wdata_i[0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_state: assert (!mode_i && sel_i == '0);
  end

  a_r3_bad_mask_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_wr && !mode_i && $countones(sel_i) != 1) |=>
      ($stable(cell_addr_i) && $stable(cell_data_i)));

  a_r9_patch_mode_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_wr && mode_i) |=> ($stable(cell_addr_i) && $stable(cell_data_i)));

  a_r5_oe_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    patch_oe_o |-> (bus_rd_i && !rom_en_o));

  a_r6_write_mode_passes_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (!patch_oe_o && data_o == rom_data_i));

  a_r7_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(grant_i) && ((grant_i & ~hit_i) == '0)));

  a_r7_grant_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |-> ((grant_i & (hit_i & (~hit_i + N_CELLS'(1)))) != '0));

  a_r8_clear_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en0_clr |=> !patch_oe_o);
endmodule

bind rom_patch_unit rpu_checker #(
  .N_CELLS(N_CELLS), .ADDR_BYTES(ADDR_BYTES), .CFG_AW(CFG_AW),
  .CFG_BASE(CFG_BASE), .AW(AW)
) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .bus_rd_i,
  .rom_data_i, .data_o, .patch_oe_o, .rom_en_o,
  .mode_i(mode_q), .sel_i(sel_q), .hit_i(hit), .grant_i(grant),
  .cell_addr_i(cell_addr_flat), .cell_data_i(cell_data_flat)
);

// File: tb/tb_rom_patch_unit.sv
module tb_rom_patch_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h1E64;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  rom_data = '0;
  logic [7:0]  data_o;
  logic        patch_oe_o, rom_en_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_patch_unit dut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .bus_addr_i(bus_addr), .bus_rd_i(bus_rd),
    .rom_data_i(rom_data), .data_o, .patch_oe_o, .rom_en_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic        m_mode;
  logic [9:0]  m_sel;
  logic [23:0] m_addr [10];
  logic [7:0]  m_data [10];

  function automatic void model_reset();
    m_mode = 1'b0; m_sel = '0;
    for (int i = 0; i < 10; i++) begin m_addr[i] = 24'hFFFFFF; m_data[i] = 8'h00; end
  endfunction

  function automatic void model_write(logic [15:0] a, logic [7:0] d);
    logic [15:0] o;
    bit one;
    o   = a - BASE;
    one = ($countones(m_sel) == 1) && !m_mode;
    if (o <= 16'd3 && one) begin
      for (int i = 0; i < 10; i++) if (m_sel[i]) begin
        if (o == 16'd3) m_data[i] = d;
        else m_addr[i][o[1:0]*8 +: 8] = d;
      end
    end else if (o == 16'd4) begin
      m_mode = d[0]; m_sel[6:0] = d[7:1];
    end else if (o == 16'd5) begin
      m_sel[9:7] = d[2:0];
    end
  endfunction

  function automatic logic [9:0] expect_out(logic [23:0] a, logic [7:0] rom, logic rd);
    for (int i = 0; i < 10; i++)
      if (m_mode && m_sel[i] && m_addr[i] == a) return {rd, 1'b0, m_data[i]};
    return {1'b0, rd, rom};
  endfunction

  task automatic check(logic [9:0] act, logic [9:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got oe=%b ren=%b data=%h, expected oe=%b ren=%b data=%h",
               req, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic probe(logic [23:0] a, logic [7:0] rom, logic rd, string req);
    bus_addr = a; rom_data = rom; bus_rd = rd;
    #1;
    check({patch_oe_o, rom_en_o, data_o}, expect_out(a, rom, rd), req);
  endtask

  task automatic cfg_write(logic [15:0] a, logic [7:0] d, logic we = 1'b1);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    if (we) model_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_cell(int c, logic [23:0] a, logic [7:0] d);
    cfg_write(BASE + 16'd5, 8'((c >= 7) ? (1 << (c - 7)) : 0));
    cfg_write(BASE + 16'd4, 8'((c < 7) ? (1 << (c + 1)) : 0));
    cfg_write(BASE + 16'd0, a[7:0]);
    cfg_write(BASE + 16'd1, a[15:8]);
    cfg_write(BASE + 16'd2, a[23:16]);
    cfg_write(BASE + 16'd3, d);
  endtask

  task automatic enable_cells(logic [9:0] m, logic [4:0] junk = '0);
    cfg_write(BASE + 16'd5, {junk, m[9:7]});
    cfg_write(BASE + 16'd4, {m[6:0], 1'b1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state passes ROM, cells hold FFFFFF / 00
    probe(24'hFFFFFF, 8'h5A, 1'b1, "R1");
    probe(24'h000000, 8'h3C, 1'b0, "R1");
    enable_cells(10'b00_0001_0000);
    probe(24'hFFFFFF, 8'h5A, 1'b1, "R1");
    check({2'b00, data_o}, 10'h000, "R1");
    cfg_write(BASE + 16'd4, 8'h00);

    // R2: byte order and data offset; R4: cell in enable register 1
    load_cell(2, 24'h123456, 8'hA5);
    load_cell(8, 24'hABCDEF, 8'h3E);
    enable_cells(10'b01_0000_0100, 5'b11111);
    probe(24'h123456, 8'h00, 1'b1, "R2");
    probe(24'hABCDEF, 8'h11, 1'b1, "R4");
    // R6: neighbour and unselected addresses pass ROM
    probe(24'h123457, 8'h77, 1'b1, "R6");
    probe(24'h563412, 8'h78, 1'b1, "R6");
    // R5: read gating of the strobes
    probe(24'h123456, 8'h99, 1'b0, "R5");

    // R11: combinational follow of address within one cycle
    probe(24'hABCDEF, 8'h22, 1'b1, "R11");
    probe(24'h000001, 8'h23, 1'b1, "R11");

    // R9: stores ignored in patch mode
    cfg_write(BASE + 16'd3, 8'h11);
    cfg_write(BASE + 16'd0, 8'h00);
    probe(24'h123456, 8'h00, 1'b1, "R9");

    // R8: patching stops at the edge that clears the mode bit
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = BASE + 16'd4; cfg_wdata = 8'h00;
    probe(24'h123456, 8'h40, 1'b1, "R8");
    @(posedge clk);
    model_write(BASE + 16'd4, 8'h00);
    @(negedge clk);
    cfg_we = 1'b0;
    probe(24'h123456, 8'h40, 1'b1, "R8");

    // R7: lowest index wins
    load_cell(1, 24'h00BEEF, 8'h01);
    load_cell(5, 24'h00BEEF, 8'h05);
    enable_cells(10'b00_0010_0010);
    probe(24'h00BEEF, 8'hFF, 1'b1, "R7");

    // R3: multi-bit and empty masks do not store
    cfg_write(BASE + 16'd4, 8'b0100_0100);  // cells 1 and 5, write mode
    cfg_write(BASE + 16'd3, 8'h77);
    cfg_write(BASE + 16'd4, 8'h00);
    cfg_write(BASE + 16'd3, 8'h66);
    enable_cells(10'b00_0010_0000);
    probe(24'h00BEEF, 8'hFF, 1'b1, "R3");

    // R10: out-of-window and strobe-low writes
    cfg_write(BASE + 16'd4, 8'h00, 1'b0);
    cfg_write(BASE - 16'd1, 8'h00);
    cfg_write(BASE + 16'd6, 8'h00);
    probe(24'h00BEEF, 8'hFF, 1'b1, "R10");

    // random phase against the model
    for (int it = 0; it < 600; it++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 4) begin
        logic [15:0] a;
        logic [7:0]  d;
        a = BASE - 16'd1 + 16'($urandom_range(0, 7));
        d = 8'($urandom);
        if (a == BASE + 16'd4 && ($urandom_range(0, 1) == 0))
          d = {8'(1 << $urandom_range(0, 6)) & 8'hFE} | 8'($urandom_range(0, 1));
        cfg_write(a, d, ($urandom_range(0, 7) != 0));
      end else begin
        logic [23:0] a;
        a = ($urandom_range(0, 2) == 0) ? 24'($urandom) : m_addr[$urandom_range(0, 9)];
        probe(a, 8'($urandom), 1'($urandom), "R5");
        @(negedge clk);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule